// File: doc/BRIEF.md
# FMA Special-Operand Result Resolver

This combinational block sits in front of the arithmetic datapath of a single-precision fused multiply-add unit. It evaluates z + p, where p is x·y, or −(x·y) when the negate-product input selects multiply-subtract. It sorts each of the three operands into one of six classes: signalling NaN, quiet NaN, infinity, zero, denormal or normal. When the classes alone fix the answer, it drives the packed 32-bit result and the invalid-operation flag and raises `special`.

Every other combination raises `compute` instead. In that case the downstream multiplier, adder and rounder produce the result. The block does no rounding and no finite arithmetic, and it does not normalise denormals. It counts a denormal factor as finite and nonzero. The rounding-mode input is used in one case only: choosing the sign of an exact zero sum.

Top module: `fma_special_resolver`

## Requirements
- R1: If any operand is a signalling NaN, the first one found in the order z, x, y is returned with fraction bit 22 set and its other bits unchanged, and `invalid` is 1.
- R2: With no signalling NaN present, the first quiet NaN found in the order z, x, y is returned bit for bit, and `invalid` is 0.
- R3: Infinity times zero, in either factor order, returns the default NaN 32'h7FC00000 with `invalid` set.
- R4: The effective product sign is x[31]^y[31]^neg_prod. If the product is infinite and z is an infinity of the opposite sign, the result is the default NaN and `invalid` is 1.
- R5: Any other infinite product returns an infinity (exponent 8'hFF, fraction 0) carrying the effective product sign, with `invalid` 0.
- R6: If one factor is zero, the other is finite, and z is infinite, the result is z.
- R7: If one factor is zero, the other is finite, and z is zero with the effective product sign, the result is z. If z is zero with the other sign, the result is a zero that is negative only when rnd_mode is 2'b11 (toward minus infinity). The other encodings are 00 nearest, 01 toward zero and 10 toward plus infinity.
- R8: If one factor is zero, the other is finite, and z is finite and nonzero (a denormal included), the result is z unchanged.
- R9: If both factors are finite and nonzero (denormals included) and z is infinite, the result is z.
- R10: In all remaining cases `compute` is 1, `res` is 0 and `invalid` is 0.
- R11: Exactly one of `special` and `compute` is 1 for every input, and `invalid` is 1 only together with `special`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 32 | Addend |
| op_x | input | 32 | First factor |
| op_y | input | 32 | Second factor |
| neg_prod | input | 1 | 1 selects z − x·y |
| rnd_mode | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward −inf |
| res | output | 32 | Resolved result; 0 when compute is 1 |
| invalid | output | 1 | Invalid-operation flag |
| special | output | 1 | Result is fully determined here |
| compute | output | 1 | Result must come from the arithmetic datapath |

## Verification
The embedded assertions assume that all three operands and both controls hold settled two-state values. They also assume a default NaN that is itself a quiet NaN, so that a quieted signalling NaN and the default NaN both satisfy the NaN-output checks. The stimulus changes inputs only on the rising clock edge and reads outputs on the falling edge. It takes every operand from a fixed pool of twelve encodings: both zeros, both infinities, normals, denormals and quiet and signalling NaNs with nonzero payloads. Every triple from that pool is swept under both negate-product settings and all four rounding modes, so all the priority and sign cases are reached and no undriven value occurs.

// File: rtl/fma_special_resolver.sv
`timescale 1ns/1ps
module fma_special_resolver #(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23,
  parameter logic [EXP_W+FRAC_W:0] DEFAULT_NAN = 32'h7FC0_0000
) (
  input  logic [EXP_W+FRAC_W:0] op_z,
  input  logic [EXP_W+FRAC_W:0] op_x,
  input  logic [EXP_W+FRAC_W:0] op_y,
  input  logic                  neg_prod,
  input  logic [1:0]            rnd_mode,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  invalid,
  output logic                  special,
  output logic                  compute
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam int NOPS = 3;
  localparam logic [1:0] RM_TO_NEG = 2'b11;

  logic [W-1:0] opnd [NOPS];
  logic [NOPS-1:0] is_snan, is_qnan, is_inf, is_zero;

  assign opnd[0] = op_z;
  assign opnd[1] = op_x;
  assign opnd[2] = op_y;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    logic exp_max, exp_min, frac_nz;
    assign exp_max    = &opnd[i][W-2 -: EXP_W];
    assign exp_min    = ~|opnd[i][W-2 -: EXP_W];
    assign frac_nz    = |opnd[i][FRAC_W-1:0];
    assign is_snan[i] = exp_max & frac_nz & ~opnd[i][FRAC_W-1];
    assign is_qnan[i] = exp_max & frac_nz & opnd[i][FRAC_W-1];
    assign is_inf[i]  = exp_max & ~frac_nz;
    assign is_zero[i] = exp_min & ~frac_nz;
  end

  logic p_sign, z_sign, prod_inf, prod_zero, inf_by_zero;
  assign p_sign      = op_x[W-1] ^ op_y[W-1] ^ neg_prod;
  assign z_sign      = op_z[W-1];
  assign prod_inf    = is_inf[1] | is_inf[2];
  assign prod_zero   = is_zero[1] | is_zero[2];
  assign inf_by_zero = (is_inf[1] & is_zero[2]) | (is_zero[1] & is_inf[2]);

  always_comb begin
    res     = '0;
    invalid = 1'b0;
    special = 1'b1;
    if (|is_snan) begin
      invalid = 1'b1;
      res = is_snan[0] ? op_z : (is_snan[1] ? op_x : op_y);
      res[FRAC_W-1] = 1'b1;
    end else if (|is_qnan) begin
      res = is_qnan[0] ? op_z : (is_qnan[1] ? op_x : op_y);
    end else if (inf_by_zero) begin
      invalid = 1'b1;
      res = DEFAULT_NAN;
    end else if (prod_inf) begin
      if (is_inf[0] && (z_sign != p_sign)) begin
        invalid = 1'b1;
        res = DEFAULT_NAN;
      end else begin
        res = {p_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end
    end else if (prod_zero) begin
      if (is_zero[0] && (z_sign != p_sign))
        res = {rnd_mode == RM_TO_NEG, {(W-1){1'b0}}};
      else
        res = op_z;
    end else if (is_inf[0]) begin
      res = op_z;
    end else begin
      special = 1'b0;
    end
  end

  assign compute = ~special;

  logic out_is_nan;
  assign out_is_nan = (&res[W-2 -: EXP_W]) & res[FRAC_W-1];

  always_comb begin
    AST_ONE_OUTCOME: assert (special ^ compute); // R11
    if (invalid) AST_INVALID_WITH_SPECIAL: assert (special); // R11
    if (compute) AST_COMPUTE_CLEAN: assert (res == '0 && !invalid); // R10
    if (|is_snan) AST_SNAN_RAISES: assert (invalid && out_is_nan); // R1
    if (~|is_snan && is_qnan[0]) AST_QNAN_Z_FIRST: assert (res == op_z && !invalid); // R2
    if (~|is_snan && ~|is_qnan && inf_by_zero) AST_INF_TIMES_ZERO: assert (res == DEFAULT_NAN && invalid); // R3
    if (~|is_snan && ~|is_qnan && ~prod_inf && ~prod_zero && is_inf[0]) AST_Z_INF_WINS: assert (res == op_z && special); // R9
  end
endmodule

// File: tb/test_fma_special_resolver.sv
`timescale 1ns/1ps
module test_fma_special_resolver;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] op_z, op_x, op_y, res;
  logic neg_prod, invalid, special, compute;
  logic [1:0] rnd_mode;

  fma_special_resolver i_fma_special_resolver (
    .op_z(op_z), .op_x(op_x), .op_y(op_y), .neg_prod(neg_prod),
    .rnd_mode(rnd_mode), .res(res), .invalid(invalid),
    .special(special), .compute(compute)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] POOL [12] = '{
    32'h0000_0000, 32'h8000_0000, 32'h7F80_0000, 32'hFF80_0000,
    32'h3F80_0000, 32'hC000_0000, 32'h0000_0001, 32'h8040_0000,
    32'h7FC0_0123, 32'hFFC0_0007, 32'h7F80_0055, 32'hFFA0_0001};

  function automatic bit f_nan(input logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction
  function automatic bit f_sig(input logic [31:0] v);
    return f_nan(v) && !v[22];
  endfunction
  function automatic bit f_inf(input logic [31:0] v);
    return v[30:0] == 31'h7F80_0000;
  endfunction
  function automatic bit f_zero(input logic [31:0] v);
    return v[30:0] == 0;
  endfunction

  // expected {res, invalid, special, compute}
  function automatic logic [34:0] expect_out(input logic [31:0] z, x, y,
      input logic n, input logic [1:0] rm, output string tag);
    logic ps;
    ps = x[31] ^ y[31] ^ n;
    tag = "R10";
    if (f_sig(z))      begin tag = "R1"; return {z | 32'h0040_0000, 3'b110}; end
    if (f_sig(x))      begin tag = "R1"; return {x | 32'h0040_0000, 3'b110}; end
    if (f_sig(y))      begin tag = "R1"; return {y | 32'h0040_0000, 3'b110}; end
    if (f_nan(z))      begin tag = "R2"; return {z, 3'b010}; end
    if (f_nan(x))      begin tag = "R2"; return {x, 3'b010}; end
    if (f_nan(y))      begin tag = "R2"; return {y, 3'b010}; end
    if ((f_inf(x) && f_zero(y)) || (f_zero(x) && f_inf(y)))
      begin tag = "R3"; return {32'h7FC0_0000, 3'b110}; end
    if (f_inf(x) || f_inf(y)) begin
      if (f_inf(z) && z[31] != ps) begin tag = "R4"; return {32'h7FC0_0000, 3'b110}; end
      tag = "R5"; return {ps, 31'h7F80_0000, 3'b010};
    end
    if (f_zero(x) || f_zero(y)) begin
      if (f_inf(z)) begin tag = "R6"; return {z, 3'b010}; end
      if (f_zero(z)) begin
        tag = "R7";
        if (z[31] == ps) return {z, 3'b010};
        return {rm == 2'b11, 31'h0, 3'b010};
      end
      tag = "R8"; return {z, 3'b010};
    end
    if (f_inf(z)) begin tag = "R9"; return {z, 3'b010}; end
    return {32'h0, 3'b001};
  endfunction

  task automatic check_now(input string tag, input logic [34:0] exp_v);
    logic [34:0] act;
    act = {res, invalid, special, compute};
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s z=%h x=%h y=%h n=%0b rm=%0d actual=%h expected=%h",
               tag, op_z, op_x, op_y, neg_prod, rnd_mode, act, exp_v);
    end
    if (special === compute) begin
      n_fail++;
      $display("FAIL R11 special/compute actual=%b%b expected one-hot", special, compute);
    end
  endtask

  initial begin
    string tag;
    logic [34:0] e;
    op_z = '0; op_x = '0; op_y = '0; neg_prod = 1'b0; rnd_mode = 2'b00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: 0 + 0*0 resolves to +0 (R7)
    check_now("R7 reset", {32'h0, 3'b010});
    for (int n = 0; n < 2; n++)
      for (int rm = 0; rm < 4; rm++)
        for (int a = 0; a < 12; a++)
          for (int b = 0; b < 12; b++)
            for (int c = 0; c < 12; c++) begin
              @(posedge clk);
              op_z = POOL[a]; op_x = POOL[b]; op_y = POOL[c];
              neg_prod = n[0]; rnd_mode = rm[1:0];
              @(negedge clk);
              e = expect_out(op_z, op_x, op_y, neg_prod, rnd_mode, tag);
              check_now(tag, e);
            end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule